// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of every line in a small direct-mapped, write-back cache. The cache sits on a snooping bus that carries one transaction at a time in a single global order. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The controller serves read and write requests from its processor. It wins the bus through a request and grant handshake when a request needs the bus. It also watches the transactions that other caches put on the bus and reacts to them in the same cycle: it drives its part of a wired-OR shared line, and it flushes a dirty block so that another cache can take it directly.

The processor holds its request steady until the done pulse. For a miss, the processor address is also the bus address, at line granularity. The low index bits select the line and the upper bits form the tag. The data array, the arbitration between caches and the memory behaviour lie outside this block. Bus command codes are fixed: 1 is a shared read, 2 is a read for ownership, 3 is an upgrade that moves no data, and 4 is a writeback.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. With no request pending, `bus_req` and `cpu_done` stay low, and the first read of any address misses.
- R2: A read miss requests the bus with command 1. At the grant, `bus_shared_in` is sampled: if it is low the line becomes Exclusive, and if it is high the line becomes Shared.
- R3: A write miss requests the bus with command 2, and the line becomes Modified at the grant.
- R4: A write hit on an Exclusive line completes in the cycle it is presented, with no bus request, and the line becomes Modified.
- R5: A write hit on a Shared line requests the bus with command 3, and the line becomes Modified at the grant.
- R6: A read hit in Modified, Exclusive or Shared raises `cpu_done` in the cycle it is presented, with no bus request.
- R7: A miss whose victim line is Modified first issues command 4, with the victim's address. The miss command follows. A clean victim is dropped with no writeback.
- R8: A snooped command 1 that hits a Modified line raises `snp_flush` and `snp_shared`, and the line becomes Shared. When it hits an Exclusive line, it raises `snp_shared` only, and the line becomes Shared.
- R9: A snooped command 2 or 3 that hits a valid line raises `snp_shared` and makes the line Invalid. A Modified line also raises `snp_flush`.
- R10: If a pending upgrade (command 3) loses its line to a snooped invalidation before the grant, the request is reissued as command 2.
- R11: `snp_flush` is raised only by a line in Modified. Clean holders never supply data.
- R12: A snooped command whose tag does not match the line at its index leaves the line unchanged and keeps `snp_shared` and `snp_flush` low.
- R13: In a cycle where `snp_valid` is high, a processor request is not serviced and `cpu_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until done |
| cpu_write | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus wanted for the command shown |
| bus_cmd | output | 3 | Command: 1 read, 2 read-own, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Line address of the command |
| bus_gnt | input | 1 | The command goes on the bus this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches, valid with the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies the snooped line's data |

## Verification
A line that holds the wrong state shows up at the ports on its next access. A line that should be Exclusive but is Shared asks for an upgrade on the next write instead of finishing at once. A line that wrongly stays valid answers a later snoop with `snp_shared`, or hits where it should miss. A lost Modified state shows up the moment another cache snoops the line: `snp_flush` stays low, or the writeback is missing when the line is evicted. The bench therefore follows each state change with a processor access or a snoop that separates the states within a few cycles.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   // line coherence state; values are internal
   typedef enum logic [1:0] {
      LS_I = 2'd0,
      LS_S = 2'd1,
      LS_E = 2'd2,
      LS_M = 2'd3
   } line_st_e;

   // bus command codes seen at the ports
   localparam logic [2:0] BC_NONE = 3'd0;
   localparam logic [2:0] BC_RD   = 3'd1;
   localparam logic [2:0] BC_RDX  = 3'd2;
   localparam logic [2:0] BC_UPGR = 3'd3;
   localparam logic [2:0] BC_WB   = 3'd4;

   // processor-side sequencer
   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_WB   = 2'd1,
      RQ_FILL = 2'd2
   } req_st_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int TAG_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output logic [TAG_W-1:0] a_tag,
   output line_st_e         a_st,
   input  logic [IDX_W-1:0] b_idx,
   output logic [TAG_W-1:0] b_tag,
   output line_st_e         b_st,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  logic [TAG_W-1:0] w_tag,
   input  line_st_e         w_st
);

   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_vec [LINES];
   line_st_e         st_vec  [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_q;
      line_st_e         st_q;
      logic             sel;

      assign sel = we && (w_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q <= '0;
            st_q  <= LS_I;
         end else if (sel) begin
            tag_q <= w_tag;
            st_q  <= w_st;
         end
      end

      assign tag_vec[g] = tag_q;
      assign st_vec[g]  = st_q;
   end

   assign a_tag = tag_vec[a_idx];
   assign a_st  = st_vec[a_idx];
   assign b_tag = tag_vec[b_idx];
   assign b_st  = st_vec[b_idx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
(
   input  logic       snp_valid,
   input  logic [2:0] snp_cmd,
   input  logic       hit,
   input  line_st_e   cur_st,
   output logic       upd,
   output line_st_e   nxt_st,
   output logic       shared,
   output logic       flush
);

   always_comb begin
      upd    = 1'b0;
      nxt_st = cur_st;
      shared = 1'b0;
      flush  = 1'b0;
      if (snp_valid && hit) begin
         unique case (snp_cmd)
            BC_RD: begin
               shared = 1'b1;
               flush  = (cur_st == LS_M);
               upd    = (cur_st != LS_S);
               nxt_st = LS_S;
            end
            BC_RDX, BC_UPGR: begin
               shared = 1'b1;
               flush  = (cur_st == LS_M);
               upd    = 1'b1;
               nxt_st = LS_I;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   input  logic              snp_valid,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              cur_hit,
   input  logic [ADDR_W-IDX_W-1:0] cur_tag,
   input  line_st_e          cur_st,
   output logic              own_we,
   output logic [ADDR_W-IDX_W-1:0] own_tag,
   output line_st_e          own_st,
   output logic              idle
);

   localparam int TAG_W = ADDR_W - IDX_W;

   req_st_e          st_q, st_d;
   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] req_idx;
   logic             granted;

   assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign req_idx = cpu_addr[IDX_W-1:0];
   assign granted = bus_gnt && !snp_valid;
   assign idle    = (st_q == RQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= RQ_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d     = st_q;
      cpu_done = 1'b0;
      bus_req  = 1'b0;
      bus_cmd  = BC_NONE;
      bus_addr = cpu_addr;
      own_we   = 1'b0;
      own_tag  = cur_tag;
      own_st   = cur_st;
      unique case (st_q)
         RQ_IDLE: begin
            if (cpu_valid && !snp_valid) begin
               if (cur_hit) begin
                  if (!cpu_write || cur_st == LS_M) begin
                     cpu_done = 1'b1;
                  end else if (cur_st == LS_E) begin
                     cpu_done = 1'b1;
                     own_we   = 1'b1;
                     own_st   = LS_M;
                  end else begin
                     st_d = RQ_FILL;
                  end
               end else if (cur_st == LS_M) begin
                  st_d = RQ_WB;
               end else begin
                  st_d = RQ_FILL;
               end
            end
         end
         RQ_WB: begin
            if (cur_st != LS_M) begin
               // a snoop already took the dirty block
               st_d = RQ_FILL;
            end else begin
               bus_req  = 1'b1;
               bus_cmd  = BC_WB;
               bus_addr = {cur_tag, req_idx};
               if (granted) begin
                  own_we = 1'b1;
                  own_st = LS_I;
                  st_d   = RQ_FILL;
               end
            end
         end
         RQ_FILL: begin
            bus_req = 1'b1;
            if (!cpu_write)                          bus_cmd = BC_RD;
            else if (cur_hit && cur_st == LS_S)      bus_cmd = BC_UPGR;
            else                                     bus_cmd = BC_RDX;
            if (granted) begin
               own_we   = 1'b1;
               own_tag  = req_tag;
               own_st   = cpu_write ? LS_M : (bus_shared_in ? LS_S : LS_E);
               cpu_done = 1'b1;
               st_d     = RQ_IDLE;
            end
         end
         default: st_d = RQ_IDLE;
      endcase
   end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("mesi_line_ctrl: IDX_W out of range");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("mesi_line_ctrl: ADDR_W must exceed IDX_W");
   end

   logic [IDX_W-1:0] cpu_idx, snp_idx;
   logic [TAG_W-1:0] cpu_tag_rd, snp_tag_rd;
   line_st_e         cpu_st, snp_st;
   logic             cpu_hit, snp_hit;

   logic             own_we;
   logic [TAG_W-1:0] own_tag;
   line_st_e         own_st;
   logic             snp_upd;
   line_st_e         snp_nxt;
   logic             fsm_idle;

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] wr_tag;
   line_st_e         wr_st;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign cpu_hit = (cpu_st != LS_I) && (cpu_tag_rd == cpu_addr[ADDR_W-1:IDX_W]);
   assign snp_hit = (snp_st != LS_I) && (snp_tag_rd == snp_addr[ADDR_W-1:IDX_W]);

   mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .a_idx (cpu_idx),
      .a_tag (cpu_tag_rd),
      .a_st  (cpu_st),
      .b_idx (snp_idx),
      .b_tag (snp_tag_rd),
      .b_st  (snp_st),
      .we    (wr_en),
      .w_idx (wr_idx),
      .w_tag (wr_tag),
      .w_st  (wr_st)
   );

   mesi_snoop_resp u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (snp_cmd),
      .hit       (snp_hit),
      .cur_st    (snp_st),
      .upd       (snp_upd),
      .nxt_st    (snp_nxt),
      .shared    (snp_shared),
      .flush     (snp_flush)
   );

   mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_valid     (cpu_valid),
      .cpu_write     (cpu_write),
      .cpu_addr      (cpu_addr),
      .cpu_done      (cpu_done),
      .snp_valid     (snp_valid),
      .bus_gnt       (bus_gnt),
      .bus_shared_in (bus_shared_in),
      .bus_req       (bus_req),
      .bus_cmd       (bus_cmd),
      .bus_addr      (bus_addr),
      .cur_hit       (cpu_hit),
      .cur_tag       (cpu_tag_rd),
      .cur_st        (cpu_st),
      .own_we        (own_we),
      .own_tag       (own_tag),
      .own_st        (own_st),
      .idle          (fsm_idle)
   );

   // snoop updates win; own updates are already held off while a snoop is present
   always_comb begin
      if (snp_upd) begin
         wr_en  = 1'b1;
         wr_idx = snp_idx;
         wr_tag = snp_tag_rd;
         wr_st  = snp_nxt;
      end else begin
         wr_en  = own_we;
         wr_idx = cpu_idx;
         wr_tag = own_tag;
         wr_st  = own_st;
      end
   end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_valid,
   input logic       cpu_write,
   input logic       cpu_done,
   input logic       bus_req,
   input logic [2:0] bus_cmd,
   input logic       snp_valid,
   input logic [2:0] snp_cmd,
   input logic       snp_shared,
   input logic       snp_flush,
   input logic       cpu_hit,
   input logic [1:0] cpu_st,
   input logic       snp_hit,
   input logic [1:0] snp_st,
   input logic       fsm_idle
);

   AST_FLUSH_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_st == 2'd3) else $error("flush from clean line"); // R11

   AST_READ_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_idle && cpu_valid && !cpu_write && cpu_hit && !snp_valid |-> cpu_done && !bus_req)
      else $error("read hit not local"); // R6

   AST_EXCL_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_idle && cpu_valid && cpu_write && cpu_hit && cpu_st == 2'd2 && !snp_valid
      |-> cpu_done && !bus_req) else $error("exclusive write used bus"); // R4

   AST_UPGRADE_NEEDS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_cmd == 3'd3 |-> cpu_hit && cpu_st == 2'd1)
      else $error("upgrade without shared copy"); // R10

   AST_WB_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_cmd == 3'd4 |-> cpu_st == 2'd3) else $error("writeback of clean line"); // R7

   AST_NO_DONE_UNDER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_done) else $error("done during snoop"); // R13

   AST_SHARED_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_hit && snp_cmd inside {3'd1, 3'd2, 3'd3} |-> snp_shared)
      else $error("shared line not driven"); // R8

   AST_QUIET_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_hit |-> !snp_shared && !snp_flush) else $error("response without hit"); // R12

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_valid  (cpu_valid),
   .cpu_write  (cpu_write),
   .cpu_done   (cpu_done),
   .bus_req    (bus_req),
   .bus_cmd    (bus_cmd),
   .snp_valid  (snp_valid),
   .snp_cmd    (snp_cmd),
   .snp_shared (snp_shared),
   .snp_flush  (snp_flush),
   .cpu_hit    (cpu_hit),
   .cpu_st     (cpu_st),
   .snp_hit    (snp_hit),
   .snp_st     (snp_st),
   .fsm_idle   (fsm_idle)
);

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb;

   localparam int AW = 12;
   localparam logic [2:0] C_RD = 3'd1, C_RDX = 3'd2, C_UPG = 3'd3, C_WB = 3'd4;
   localparam logic [AW-1:0] A_A = 12'h010, A_B = 12'h018, A_C = 12'h020,
                             A_X = 12'h028, A_D = 12'h031, A_E = 12'h042;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_valid = 1'b0, cpu_write = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic cpu_done, bus_req;
   logic [2:0] bus_cmd;
   logic [AW-1:0] bus_addr;
   logic bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic snp_valid = 1'b0;
   logic [2:0] snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic snp_shared, snp_flush;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
      .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_shared(snp_shared), .snp_flush(snp_flush)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one processor access, granting every request at once
   task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic shr,
                         output int n, output logic [2:0] c0, output logic [AW-1:0] a0,
                         output logic [2:0] c1, output logic [AW-1:0] a1, output int cyc);
      bit fin = 0;
      n = 0; cyc = 0; c0 = '0; c1 = '0; a0 = '0; a1 = '0;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
      for (int k = 0; k < 20 && !fin; k++) begin
         #1;
         cyc++;
         if (bus_req) begin
            if (n == 0) begin c0 = bus_cmd; a0 = bus_addr; end
            else        begin c1 = bus_cmd; a1 = bus_addr; end
            n++;
            bus_gnt = 1'b1; bus_shared_in = shr;
            #1;
         end
         if (cpu_done) fin = 1;
         @(negedge clk);
         bus_gnt = 1'b0; bus_shared_in = 1'b0;
      end
      cpu_valid = 1'b0; cpu_write = 1'b0;
   endtask

   task automatic do_snoop(input logic [2:0] c, input logic [AW-1:0] a,
                           output logic sh, output logic fl);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
      #1;
      sh = snp_shared; fl = snp_flush;
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = '0;
   endtask

   task automatic t_reset;
      int n, cyc; logic [2:0] c0, c1; logic [AW-1:0] a0, a1;
      chk(bus_req == 0, "R1 idle bus_req", bus_req, 0);
      chk(cpu_done == 0, "R1 idle cpu_done", cpu_done, 0);
      do_req(1'b0, A_A, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_RD, "R1 R2 first read misses with cmd", c0, C_RD);
      chk(a0 == A_A, "R2 read miss address", a0, A_A);
   endtask

   task automatic t_excl_write;
      int n, cyc; logic [2:0] c0, c1; logic [AW-1:0] a0, a1; logic sh, fl;
      do_req(1'b1, A_A, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 0 && cyc == 1, "R4 exclusive write silent, cycles", cyc, 1);
      do_snoop(C_RD, A_A, sh, fl);
      chk(fl == 1 && sh == 1, "R8 R4 snoop read of modified flushes", fl, 1);
      do_req(1'b1, A_A, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_UPG, "R5 R8 write to shared upgrades", c0, C_UPG);
   endtask

   task automatic t_snoop_inval;
      int n, cyc; logic [2:0] c0, c1; logic [AW-1:0] a0, a1; logic sh, fl;
      do_snoop(C_RD, A_A, sh, fl);
      chk(fl == 1, "R5 line was modified after upgrade", fl, 1);
      do_snoop(C_RDX, A_A, sh, fl);
      chk(sh == 1 && fl == 0, "R11 R9 shared holder does not flush", fl, 0);
      do_req(1'b0, A_A, 1'b1, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_RD, "R9 invalidated line misses", c0, C_RD);
      do_req(1'b0, A_A, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 0 && cyc == 1, "R6 read hit in one cycle", cyc, 1);
   endtask

   task automatic t_upgr_convert;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = A_A;
      #1;
      chk(bus_req == 0, "R10 no request in lookup cycle", bus_req, 0);
      @(negedge clk);
      #1;
      chk(bus_req == 1 && bus_cmd == C_UPG, "R2 R10 upgrade pending (line shared)", bus_cmd, C_UPG);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = C_UPG; snp_addr = A_A;
      #1;
      chk(snp_shared == 1 && snp_flush == 0, "R9 snooped upgrade on shared", snp_flush, 0);
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = '0;
      #1;
      chk(bus_req == 1 && bus_cmd == C_RDX, "R10 request converted", bus_cmd, C_RDX);
      bus_gnt = 1'b1;
      #1;
      chk(cpu_done == 1, "R10 done at grant", cpu_done, 1);
      @(negedge clk);
      bus_gnt = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0;
   endtask

   task automatic t_evict;
      int n, cyc; logic [2:0] c0, c1; logic [AW-1:0] a0, a1; logic sh, fl;
      do_req(1'b0, A_B, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 2 && c0 == C_WB, "R7 dirty victim written back first", c0, C_WB);
      chk(a0 == A_A, "R7 writeback address", a0, A_A);
      chk(c1 == C_RD && a1 == A_B, "R7 miss follows writeback", c1, C_RD);
      do_snoop(C_RD, A_X, sh, fl);
      chk(sh == 0 && fl == 0, "R12 tag mismatch snoop quiet", sh, 0);
      do_req(1'b0, A_B, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 0, "R12 line kept after foreign snoop", n, 0);
      do_req(1'b0, A_C, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_RD, "R7 clean victim dropped", n, 1);
      do_snoop(C_RD, A_C, sh, fl);
      chk(sh == 1 && fl == 0, "R8 R11 exclusive answers shared only", fl, 0);
      do_req(1'b1, A_C, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_UPG, "R8 exclusive became shared", c0, C_UPG);
   endtask

   task automatic t_write_miss;
      int n, cyc; logic [2:0] c0, c1; logic [AW-1:0] a0, a1; logic sh, fl;
      do_req(1'b1, A_D, 1'b1, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_RDX, "R3 write miss cmd", c0, C_RDX);
      do_snoop(C_RD, A_D, sh, fl);
      chk(fl == 1, "R3 write miss left line modified", fl, 1);
      do_req(1'b1, A_E, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_RDX, "R3 second write miss", c0, C_RDX);
      do_snoop(C_RDX, A_E, sh, fl);
      chk(sh == 1 && fl == 1, "R9 read-own on modified flushes", fl, 1);
      do_req(1'b0, A_E, 1'b0, n, c0, a0, c1, a1, cyc);
      chk(n == 1 && c0 == C_RD, "R9 modified line invalidated", c0, C_RD);
   endtask

   task automatic t_snoop_blocks;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = A_C;
      snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = 12'h0A1;
      #1;
      chk(cpu_done == 0, "R13 no service during snoop", cpu_done, 0);
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = '0;
      #1;
      chk(cpu_done == 1 && bus_req == 0, "R13 R6 serviced after snoop", cpu_done, 1);
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_excl_write();
      t_snoop_inval();
      t_upgr_convert();
      t_evict();
      t_write_miss();
      t_snoop_blocks();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule